// File: doc/BRIEF.md
# Layered Perceptron Inference Sequencer

This block drives one shared neuron engine through every layer of a feed-forward perceptron. The input vector, all trained weights and all biases sit in external memories before a run begins. A pulse on `start_i` launches the run. For each neuron the sequencer clears the engine, streams the neuron's fan-in to it M operands at a time, and then presents the bias together with an activate strobe. When the engine reports its result, the sequencer writes it to a two-bank result memory.

The first hidden layer takes its operands from the input memory. Every later layer reads the bank that the previous layer wrote. A comparison stage tracks the largest output of the final layer and delivers the winning class index with a one-cycle finish pulse.

All memories answer a read one clock after the address is presented. Sizes are set by parameters: the input width `N_IN`, the hidden width `N_HID`, the number of hidden layers `HID_LAYERS`, the class count `N_OUT`, the lane count `M` and the data width `DW`.

Top module: `mlp_sequencer`

## Requirements
- R1: While `rst_n` is low and after its release, all strobes (`nrn_clear_o`, `nrn_en_o`, `nrn_activ_o`, `res_wr_en_o`, `run_done_o`, `layer_restart_o`) are low and `class_idx_o` is 0.
- R2: Each neuron starts with exactly one `nrn_clear_o` cycle. It then receives ceil(fan_in/M) `nrn_en_o` beats, where fan_in is `N_IN` for layer 0 and `N_HID` for every later layer. Exactly one `nrn_activ_o` cycle follows. No two of clear, enable, activate and result write are ever high together.
- R3: On enable beat b, lane j of `nrn_x_o` (bits j*DW+:DW) carries operand b*M+j. For layer 0 this comes from the input memory word at address b. For layer L>0 it comes from result bank (L-1) mod 2 at beat b, where beat b returns entries b*M..b*M+M-1. Lane j of `nrn_w_o` comes from the weight word at a running address: it starts at 0 for each run and advances once per beat, in layer, neuron, beat order.
- R4: Lanes whose operand index is at or beyond the layer's fan-in are driven as zero on both `nrn_x_o` and `nrn_w_o`, whatever the memories return.
- R5: While `nrn_activ_o` is high, `nrn_bias_o` carries the bias word at address L*N_HID+n, for layer L and neuron n.
- R6: In the cycle `nrn_done_i` is high, `nrn_y_i` is written to result bank L mod 2 at index n.
- R7: The next neuron is not cleared until the engine has returned the current one, however many cycles it takes.
- R8: `layer_restart_o` pulses for one cycle together with the first clear of every layer, so it pulses HID_LAYERS+1 times per run.
- R9: The class index is the final-layer neuron with the largest signed output. On a tie, the lowest index wins.
- R10: `run_done_o` is a single-cycle pulse, and the new `class_idx_o` is valid in that same cycle. `class_idx_o` changes at no other time, so it holds through the next run until that run finishes.
- R11: A `start_i` pulse while a run is in progress is ignored. The run completes with unchanged operand order and restart count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a run (idle only) |
| layer_restart_o | output | 1 | Pulse at the start of each layer |
| run_done_o | output | 1 | One-cycle finish pulse |
| class_idx_o | output | aw(N_OUT) | Winning class |
| in_rd_addr_o | output | BTW | Input memory word address (beat) |
| in_rd_data_i | input | M*DW | Input memory word, one cycle later |
| w_rd_addr_o | output | WAW | Weight memory word address |
| w_rd_data_i | input | M*DW | Weight word, one cycle later |
| b_rd_addr_o | output | BAW | Bias address |
| b_rd_data_i | input | DW | Bias word, one cycle later |
| res_rd_bank_o | output | 1 | Result bank to read |
| res_rd_beat_o | output | BTW | Result beat to read |
| res_rd_data_i | input | M*DW | M result entries, one cycle later |
| res_wr_en_o | output | 1 | Result write strobe |
| res_wr_bank_o | output | 1 | Result bank to write |
| res_wr_idx_o | output | NAW | Result entry index |
| res_wr_data_o | output | DW | Result value |
| nrn_clear_o | output | 1 | Clear the neuron accumulator |
| nrn_en_o | output | 1 | Operand beat valid |
| nrn_activ_o | output | 1 | Apply bias and activation |
| nrn_x_o | output | M*DW | Operand lanes |
| nrn_w_o | output | M*DW | Weight lanes |
| nrn_bias_o | output | DW | Bias during activate |
| nrn_done_i | input | 1 | Neuron result valid |
| nrn_y_i | input | DW | Neuron result |

## Verification
The embedded assertions check properties that must hold in every cycle. The four neuron-side strobes never overlap, activate and finish are single pulses, a layer restart always coincides with a clear, and the class output only moves when finish is high. The bench's scenarios are the only evidence for the rest. Those scenarios cover the lane-exact operand and weight ordering across layers and both result banks, and zero masking of the padded lanes. They also cover bias addressing, waiting on a slow engine, argmax tie handling at the first and last positions, and an ignored start during a run.

// File: rtl/mlp_seq_pkg.sv
// Shared types and helpers for the perceptron sequencer.
package mlp_seq_pkg;

    // Controller states, in the order a neuron passes through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_FEED,
        ST_BIAS,
        ST_ACT,
        ST_WAIT,
        ST_FIN
    } seq_state_t;

    // Integer ceiling division.
    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Address width able to index n entries, at least one bit.
    function automatic int aw(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mlp_seq_ctrl.sv
// Neuron/layer stepping state machine.
// Walks layers, neurons and fan-in beats, keeps a running weight word count,
// and emits the engine strobes. Assumes one-cycle memory read latency: the
// enable strobe is the feed state delayed by one register.
module mlp_seq_ctrl
    import mlp_seq_pkg::*;
#(
    parameter int LAYERS    = 3,
    parameter int N_HID     = 6,
    parameter int N_OUT     = 4,
    parameter int BEATS_IN  = 5,
    parameter int BEATS_HID = 2,
    parameter int LW        = 2,
    parameter int NAW       = 3,
    parameter int BTW       = 3,
    parameter int WAW       = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           nrn_done_i,
    output logic [LW-1:0]  layer_o,
    output logic [NAW-1:0] nrn_o,
    output logic [BTW-1:0] beat_o,
    output logic [BTW-1:0] beat_q_o,
    output logic [WAW-1:0] wcnt_o,
    output logic           clear_o,
    output logic           feed_o,
    output logic           activ_o,
    output logic           wr_o,
    output logic           restart_o,
    output logic           finish_o
);

    seq_state_t     state;
    logic [LW-1:0]  layer;
    logic [NAW-1:0] nrn;
    logic [BTW-1:0] beat;
    logic [BTW-1:0] beat_q;
    logic [WAW-1:0] wcnt;
    logic           feed_q;
    logic           restart_q;
    int             nb;
    int             nn;

    // Beats per neuron and neurons per layer for the current layer.
    always_comb begin
        nb = (layer == '0) ? BEATS_IN : BEATS_HID;
        nn = (int'(layer) == LAYERS - 1) ? N_OUT : N_HID;
    end

    // State, counters and the delayed feed strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            layer     <= '0;
            nrn       <= '0;
            beat      <= '0;
            beat_q    <= '0;
            wcnt      <= '0;
            feed_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            feed_q    <= (state == ST_FEED);
            beat_q    <= beat;
            restart_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        layer     <= '0;
                        nrn       <= '0;
                        wcnt      <= '0;
                        restart_q <= 1'b1;
                        state     <= ST_CLR;
                    end
                end
                ST_CLR: begin
                    beat  <= '0;
                    state <= ST_FEED;
                end
                ST_FEED: begin
                    wcnt <= wcnt + WAW'(1);
                    if (int'(beat) == nb - 1) begin
                        state <= ST_BIAS;
                    end else begin
                        beat <= beat + BTW'(1);
                    end
                end
                ST_BIAS: state <= ST_ACT;
                ST_ACT:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (nrn_done_i) begin
                        if (int'(nrn) == nn - 1) begin
                            nrn <= '0;
                            if (int'(layer) == LAYERS - 1) begin
                                state <= ST_FIN;
                            end else begin
                                layer     <= layer + LW'(1);
                                restart_q <= 1'b1;
                                state     <= ST_CLR;
                            end
                        end else begin
                            nrn   <= nrn + NAW'(1);
                            state <= ST_CLR;
                        end
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe and counter outputs.
    always_comb begin
        layer_o   = layer;
        nrn_o     = nrn;
        beat_o    = beat;
        beat_q_o  = beat_q;
        wcnt_o    = wcnt;
        clear_o   = (state == ST_CLR);
        feed_o    = feed_q;
        activ_o   = (state == ST_ACT);
        wr_o      = (state == ST_WAIT) && nrn_done_i;
        restart_o = restart_q;
        finish_o  = (state == ST_FIN);
    end

    // R2: the engine never sees two commands in one cycle.
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_o, feed_o, activ_o, wr_o}));

    // R2: activate lasts a single cycle.
    a_r2_activ_single: assert property (@(posedge clk) disable iff (!rst_n)
        activ_o |=> !activ_o);

    // R8: a layer restart comes with the clear of that layer's first neuron.
    a_r8_restart_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> clear_o);

    // R10: finish is a single-cycle pulse.
    a_r10_finish_single: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !finish_o);

endmodule

// File: rtl/mlp_operand_mux.sv
// Operand source select and lane masking.
// Picks the input memory word for layer 0 and the fed-back result word for
// later layers, and zeroes every lane whose operand index is past the fan-in.
// Outputs are zero when no beat is in flight.
module mlp_operand_mux #(
    parameter int DW    = 10,
    parameter int M     = 4,
    parameter int N_IN  = 20,
    parameter int N_HID = 6,
    parameter int BTW   = 3
) (
    input  logic            use_result_i,
    input  logic            feed_i,
    input  logic [BTW-1:0]  beat_i,
    input  logic [M*DW-1:0] in_data_i,
    input  logic [M*DW-1:0] res_data_i,
    input  logic [M*DW-1:0] w_data_i,
    output logic [M*DW-1:0] x_o,
    output logic [M*DW-1:0] w_o
);

    int fan;

    // Fan-in of the layer being fed.
    always_comb fan = use_result_i ? N_HID : N_IN;

    for (genvar j = 0; j < M; j++) begin : g_lane
        logic live;
        // Lane is live when its operand index lies inside the fan-in.
        always_comb begin
            live = feed_i && ((int'(beat_i) * M + j) < fan);
            x_o[j*DW +: DW] = live ? (use_result_i ? res_data_i[j*DW +: DW]
                                                   : in_data_i[j*DW +: DW]) : '0;
            w_o[j*DW +: DW] = live ? w_data_i[j*DW +: DW] : '0;
        end
    end

endmodule

// File: rtl/mlp_argmax.sv
// Running maximum over the final layer.
// Each final-layer write is compared, signed, with the best so far; only a
// strictly larger value displaces it, so ties keep the lower index. The class
// register loads on the last write of the run and holds otherwise.
module mlp_argmax #(
    parameter int DW = 10,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic          first_i,
    input  logic          commit_i,
    input  logic [DW-1:0] y_i,
    input  logic [CW-1:0] idx_i,
    output logic [CW-1:0] class_o
);

    logic signed [DW-1:0] best_val;
    logic [CW-1:0]        best_idx;
    logic                 take;
    logic [CW-1:0]        nxt_idx;

    // Decide whether the incoming value becomes the new leader.
    always_comb begin
        take    = first_i || ($signed(y_i) > best_val);
        nxt_idx = take ? idx_i : best_idx;
    end

    // Leader tracking and class commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_val <= '0;
            best_idx <= '0;
            class_o  <= '0;
        end else begin
            if (upd_i && take) begin
                best_val <= $signed(y_i);
                best_idx <= idx_i;
            end
            if (commit_i) class_o <= nxt_idx;
        end
    end

endmodule

// File: rtl/mlp_sequencer.sv
// Top of the perceptron inference sequencer.
// Reuses one neuron engine over all layers, with a two-bank result memory:
// layer L writes bank L mod 2 and reads bank (L-1) mod 2. Assumes every
// external memory returns data one cycle after the address.
module mlp_sequencer
    import mlp_seq_pkg::*;
#(
    parameter int DW         = 10,
    parameter int M          = 4,
    parameter int N_IN       = 20,
    parameter int N_HID      = 6,
    parameter int N_OUT      = 4,
    parameter int HID_LAYERS = 2,
    localparam int LAYERS    = HID_LAYERS + 1,
    localparam int BEATS_IN  = cdiv(N_IN, M),
    localparam int BEATS_HID = cdiv(N_HID, M),
    localparam int NMAX      = (N_HID > N_OUT) ? N_HID : N_OUT,
    localparam int W_WORDS   = N_HID * BEATS_IN + (HID_LAYERS - 1) * N_HID * BEATS_HID
                               + N_OUT * BEATS_HID,
    localparam int B_WORDS   = HID_LAYERS * N_HID + N_OUT,
    localparam int BTW       = aw((BEATS_IN > BEATS_HID) ? BEATS_IN : BEATS_HID),
    localparam int WAW       = aw(W_WORDS + 1),
    localparam int BAW       = aw(B_WORDS),
    localparam int NAW       = aw(NMAX),
    localparam int LW        = aw(LAYERS),
    localparam int CW        = aw(N_OUT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic            layer_restart_o,
    output logic            run_done_o,
    output logic [CW-1:0]   class_idx_o,
    output logic [BTW-1:0]  in_rd_addr_o,
    input  logic [M*DW-1:0] in_rd_data_i,
    output logic [WAW-1:0]  w_rd_addr_o,
    input  logic [M*DW-1:0] w_rd_data_i,
    output logic [BAW-1:0]  b_rd_addr_o,
    input  logic [DW-1:0]   b_rd_data_i,
    output logic            res_rd_bank_o,
    output logic [BTW-1:0]  res_rd_beat_o,
    input  logic [M*DW-1:0] res_rd_data_i,
    output logic            res_wr_en_o,
    output logic            res_wr_bank_o,
    output logic [NAW-1:0]  res_wr_idx_o,
    output logic [DW-1:0]   res_wr_data_o,
    output logic            nrn_clear_o,
    output logic            nrn_en_o,
    output logic            nrn_activ_o,
    output logic [M*DW-1:0] nrn_x_o,
    output logic [M*DW-1:0] nrn_w_o,
    output logic [DW-1:0]   nrn_bias_o,
    input  logic            nrn_done_i,
    input  logic [DW-1:0]   nrn_y_i
);

    logic [LW-1:0]  layer;
    logic [NAW-1:0] nrn;
    logic [BTW-1:0] beat;
    logic [BTW-1:0] beat_q;
    logic [WAW-1:0] wcnt;
    logic           clear;
    logic           feed;
    logic           activ;
    logic           wr;
    logic           restart;
    logic           finish;
    logic           last_layer;
    logic           commit;

    mlp_seq_ctrl #(
        .LAYERS(LAYERS), .N_HID(N_HID), .N_OUT(N_OUT),
        .BEATS_IN(BEATS_IN), .BEATS_HID(BEATS_HID),
        .LW(LW), .NAW(NAW), .BTW(BTW), .WAW(WAW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .nrn_done_i(nrn_done_i),
        .layer_o(layer), .nrn_o(nrn), .beat_o(beat), .beat_q_o(beat_q),
        .wcnt_o(wcnt), .clear_o(clear), .feed_o(feed), .activ_o(activ),
        .wr_o(wr), .restart_o(restart), .finish_o(finish)
    );

    mlp_operand_mux #(
        .DW(DW), .M(M), .N_IN(N_IN), .N_HID(N_HID), .BTW(BTW)
    ) u_mux (
        .use_result_i(layer != '0), .feed_i(feed), .beat_i(beat_q),
        .in_data_i(in_rd_data_i), .res_data_i(res_rd_data_i),
        .w_data_i(w_rd_data_i), .x_o(nrn_x_o), .w_o(nrn_w_o)
    );

    // Final-layer write detection for the argmax stage.
    always_comb begin
        last_layer = (int'(layer) == LAYERS - 1);
        commit     = wr && last_layer && (int'(nrn) == N_OUT - 1);
    end

    mlp_argmax #(.DW(DW), .CW(CW)) u_argmax (
        .clk(clk), .rst_n(rst_n), .upd_i(wr && last_layer),
        .first_i(nrn == '0), .commit_i(commit), .y_i(nrn_y_i),
        .idx_i(nrn[CW-1:0]), .class_o(class_idx_o)
    );

    // Memory addressing and engine-facing outputs.
    always_comb begin
        in_rd_addr_o    = beat;
        res_rd_beat_o   = beat;
        res_rd_bank_o   = ~layer[0];
        w_rd_addr_o     = wcnt;
        b_rd_addr_o     = BAW'(int'(layer) * N_HID + int'(nrn));
        res_wr_en_o     = wr;
        res_wr_bank_o   = layer[0];
        res_wr_idx_o    = nrn;
        res_wr_data_o   = nrn_y_i;
        nrn_clear_o     = clear;
        nrn_en_o        = feed;
        nrn_activ_o     = activ;
        nrn_bias_o      = activ ? b_rd_data_i : '0;
        layer_restart_o = restart;
        run_done_o      = finish;
    end

    // R10: the class output only moves in the finish cycle.
    a_r10_class_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(class_idx_o) |-> run_done_o);

endmodule

// File: tb/mlp_sequencer_test.sv
// Bench: behavioural network model builds queues of expected beats, biases,
// writes and class, compared against the ports on every clock.
module mlp_sequencer_test;
    import mlp_seq_pkg::*;

    localparam int DW = 10, M = 4, N_IN = 20, N_HID = 6, N_OUT = 4, HID_LAYERS = 2;
    localparam int LAYERS    = HID_LAYERS + 1;
    localparam int BEATS_IN  = cdiv(N_IN, M);
    localparam int BEATS_HID = cdiv(N_HID, M);
    localparam int NMAX      = (N_HID > N_OUT) ? N_HID : N_OUT;
    localparam int RBEATS    = cdiv(NMAX, M);
    localparam int W_WORDS   = N_HID * BEATS_IN + (HID_LAYERS - 1) * N_HID * BEATS_HID
                               + N_OUT * BEATS_HID;
    localparam int B_WORDS   = HID_LAYERS * N_HID + N_OUT;
    localparam int BTW = aw((BEATS_IN > BEATS_HID) ? BEATS_IN : BEATS_HID);
    localparam int WAW = aw(W_WORDS + 1), BAW = aw(B_WORDS), NAW = aw(NMAX), CW = aw(N_OUT);
    localparam int FANMAX = (N_IN > N_HID) ? N_IN : N_HID;
    localparam int MAXV = 2 ** (DW - 1) - 1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic restart_o, done_o;
    logic [CW-1:0] class_o;
    logic [BTW-1:0] in_addr, r_beat;
    logic [WAW-1:0] w_addr;
    logic [BAW-1:0] b_addr;
    logic [M*DW-1:0] in_rd, w_rd, r_rd, x_o, wl_o;
    logic [DW-1:0] b_rd, wr_data, bias_o, nrn_y;
    logic r_bank, wr_en, wr_bank, clr, en, act, nrn_done;
    logic [NAW-1:0] wr_idx;

    always #5 clk = ~clk;

    mlp_sequencer #(.DW(DW), .M(M), .N_IN(N_IN), .N_HID(N_HID), .N_OUT(N_OUT),
                    .HID_LAYERS(HID_LAYERS)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .layer_restart_o(restart_o),
        .run_done_o(done_o), .class_idx_o(class_o),
        .in_rd_addr_o(in_addr), .in_rd_data_i(in_rd),
        .w_rd_addr_o(w_addr), .w_rd_data_i(w_rd),
        .b_rd_addr_o(b_addr), .b_rd_data_i(b_rd),
        .res_rd_bank_o(r_bank), .res_rd_beat_o(r_beat), .res_rd_data_i(r_rd),
        .res_wr_en_o(wr_en), .res_wr_bank_o(wr_bank), .res_wr_idx_o(wr_idx),
        .res_wr_data_o(wr_data), .nrn_clear_o(clr), .nrn_en_o(en), .nrn_activ_o(act),
        .nrn_x_o(x_o), .nrn_w_o(wl_o), .nrn_bias_o(bias_o),
        .nrn_done_i(nrn_done), .nrn_y_i(nrn_y)
    );

    // ---------------- memories ----------------
    logic [M*DW-1:0] in_mem [BEATS_IN];
    logic [M*DW-1:0] w_mem [W_WORDS];
    logic [DW-1:0]   b_mem [B_WORDS];
    logic [DW-1:0]   r_mem [2][RBEATS*M];

    always @(posedge clk) begin
        in_rd <= (int'(in_addr) < BEATS_IN) ? in_mem[int'(in_addr) % BEATS_IN] : '0;
        w_rd  <= (int'(w_addr) < W_WORDS) ? w_mem[int'(w_addr) % W_WORDS] : '0;
        b_rd  <= (int'(b_addr) < B_WORDS) ? b_mem[int'(b_addr) % B_WORDS] : '0;
        for (int j = 0; j < M; j++) begin
            int k;
            k = int'(r_beat) * M + j;
            r_rd[j*DW +: DW] <= (k < RBEATS*M) ? r_mem[r_bank][k % (RBEATS*M)] : '0;
        end
        if (wr_en) r_mem[wr_bank][int'(wr_idx)] <= wr_data;
    end

    // ---------------- neuron engine model ----------------
    int acc, lat = 1, pend_cnt, y_hold;

    function automatic int lanev(input logic [M*DW-1:0] v, input int j);
        logic signed [DW-1:0] t;
        t = v[j*DW +: DW];
        return int'(t);
    endfunction

    function automatic int clampv(input int v);
        return (v < 0) ? 0 : ((v > MAXV) ? MAXV : v);
    endfunction

    always @(posedge clk) begin
        nrn_done <= 1'b0;
        if (!rst_n) begin
            acc = 0; pend_cnt = 0; nrn_y <= '0;
        end else begin
            if (clr) acc = 0;
            if (en) for (int j = 0; j < M; j++) acc += lanev(x_o, j) * lanev(wl_o, j);
            if (act) begin
                logic signed [DW-1:0] bb;
                bb = bias_o;
                y_hold = clampv(acc + int'(bb));
                pend_cnt = lat;
            end else if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    nrn_done <= 1'b1;
                    nrn_y <= DW'(y_hold);
                end
            end
        end
    end

    // ---------------- reference network ----------------
    int in_v [N_IN];
    int wt [LAYERS][NMAX][FANMAX];
    int bs [LAYERS][NMAX];
    logic [M*DW-1:0] q_x[$], q_w[$];
    int q_b[$], q_nb[$], q_bank[$], q_idx[$], q_y[$];
    int exp_class, cls_hold;
    int n_cmp = 0, n_bad = 0;
    int restarts, dones, beat_cnt;
    bit pending, prev_done, mon_on, got_done;
    int unsigned seed;

    function automatic int fanf(input int l); return (l == 0) ? N_IN : N_HID; endfunction
    function automatic int nnf(input int l); return (l == LAYERS - 1) ? N_OUT : N_HID; endfunction
    function automatic int nbf(input int l); return cdiv(fanf(l), M); endfunction

    function automatic int rnd(input int lo, input int hi);
        seed = seed * 1103515245 + 12345;
        return lo + int'((seed >> 16) % (hi - lo + 1));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act_v, input longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic fill_random(input int unsigned s);
        seed = s;
        for (int i = 0; i < N_IN; i++) in_v[i] = rnd(0, 7);
        for (int l = 0; l < LAYERS; l++)
            for (int n = 0; n < NMAX; n++) begin
                bs[l][n] = rnd(-8, 8);
                for (int k = 0; k < FANMAX; k++) wt[l][n][k] = rnd(-3, 3);
            end
    endtask

    // Pack memories (with junk in padding lanes) and build expectation queues.
    task automatic prepare();
        int a, act_v[FANMAX], nxt[FANMAX], best;
        a = 0;
        for (int b = 0; b < BEATS_IN; b++)
            for (int j = 0; j < M; j++)
                in_mem[b][j*DW +: DW] = DW'((b*M + j < N_IN) ? in_v[(b*M + j) % N_IN] : 37);
        for (int l = 0; l < LAYERS; l++)
            for (int n = 0; n < nnf(l); n++) begin
                b_mem[l*N_HID + n] = DW'(bs[l][n]);
                for (int b = 0; b < nbf(l); b++) begin
                    for (int j = 0; j < M; j++)
                        w_mem[a][j*DW +: DW] = DW'((b*M + j < fanf(l)) ? wt[l][n][b*M + j] : -5);
                    a++;
                end
            end
        for (int k = 0; k < RBEATS*M; k++) begin r_mem[0][k] = DW'(77); r_mem[1][k] = DW'(77); end
        q_x.delete(); q_w.delete(); q_b.delete(); q_nb.delete();
        q_bank.delete(); q_idx.delete(); q_y.delete();
        for (int i = 0; i < FANMAX; i++) act_v[i] = (i < N_IN) ? in_v[i] : 0;
        for (int l = 0; l < LAYERS; l++) begin
            for (int n = 0; n < nnf(l); n++) begin
                int s;
                s = 0;
                for (int b = 0; b < nbf(l); b++) begin
                    logic [M*DW-1:0] px, pw;
                    px = '0; pw = '0;
                    for (int j = 0; j < M; j++) begin
                        int k;
                        k = b*M + j;
                        if (k < fanf(l)) begin
                            px[j*DW +: DW] = DW'(act_v[k]);
                            pw[j*DW +: DW] = DW'(wt[l][n][k]);
                            s += act_v[k] * wt[l][n][k];
                        end
                    end
                    q_x.push_back(px); q_w.push_back(pw);
                end
                q_nb.push_back(nbf(l));
                q_b.push_back(bs[l][n]);
                nxt[n] = clampv(s + bs[l][n]);
                q_bank.push_back(l % 2); q_idx.push_back(n); q_y.push_back(nxt[n]);
            end
            for (int i = 0; i < FANMAX; i++) act_v[i] = (i < nnf(l)) ? nxt[i] : 0;
        end
        best = 0;
        for (int n = 1; n < N_OUT; n++) if (act_v[n] > act_v[best]) best = n;
        exp_class = best;
    endtask

    // ---------------- per-clock monitor ----------------
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (clr) begin
                chk(!pending, "R7", "clear while neuron pending", 1, 0);
                beat_cnt = 0;
            end
            if (en) begin
                beat_cnt++;
                if (q_x.size() == 0) chk(0, "R2", "extra enable beat", 1, 0);
                else begin
                    logic [M*DW-1:0] ex, ew;
                    ex = q_x.pop_front(); ew = q_w.pop_front();
                    chk(x_o == ex, "R3 R4", "operand lanes", longint'(x_o), longint'(ex));
                    chk(wl_o == ew, "R3 R4", "weight lanes", longint'(wl_o), longint'(ew));
                end
            end
            if (act) begin
                logic signed [DW-1:0] bb;
                int eb, en_exp;
                bb = bias_o;
                eb = (q_b.size() > 0) ? q_b.pop_front() : 9999;
                en_exp = (q_nb.size() > 0) ? q_nb.pop_front() : -1;
                chk(beat_cnt == en_exp, "R2", "enable beats per neuron", beat_cnt, en_exp);
                chk(int'(bb) == eb, "R5", "bias", int'(bb), eb);
                pending = 1;
            end
            if (wr_en) begin
                int eb, ei, ey;
                eb = (q_bank.size() > 0) ? q_bank.pop_front() : -1;
                ei = (q_idx.size() > 0) ? q_idx.pop_front() : -1;
                ey = (q_y.size() > 0) ? q_y.pop_front() : -1;
                chk(int'(wr_bank) == eb, "R6", "write bank", wr_bank, eb);
                chk(int'(wr_idx) == ei, "R6", "write index", wr_idx, ei);
                chk(int'(wr_data) == ey, "R6", "write data", wr_data, ey);
                pending = 0;
            end
            if (restart_o) begin
                restarts++;
                chk(clr, "R8", "restart without clear", 0, 1);
            end
            if (done_o) begin
                dones++;
                got_done = 1;
                chk(!prev_done, "R10", "finish wider than one cycle", 1, 0);
                chk(int'(class_o) == exp_class, "R9", "class index", class_o, exp_class);
                cls_hold = int'(class_o);
            end else begin
                chk(int'(class_o) == cls_hold, "R10", "class moved outside finish", class_o, cls_hold);
            end
            prev_done = done_o;
        end
    end

    task automatic run(input int latency, input bit busy_go, input string tag);
        lat = latency;
        prepare();
        restarts = 0; dones = 0; got_done = 0; pending = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 5000 && !got_done; c++) begin
            if (busy_go && c == 30) start = 1'b1;   // R11: ignored while busy
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(got_done, "R2", {"watchdog ", tag}, got_done, 1);
        repeat (3) @(negedge clk);
        chk(q_x.size() == 0 && q_b.size() == 0 && q_y.size() == 0, "R2",
            {"queues drained ", tag}, q_x.size() + q_y.size(), 0);
        chk(restarts == LAYERS, "R8", {"restart count ", tag}, restarts, LAYERS);
        chk(dones == 1, busy_go ? "R11" : "R10", {"finish count ", tag}, dones, 1);
    endtask

    initial begin
        mon_on = 0; cls_hold = 0; prev_done = 0; exp_class = 0;
        fill_random(32'h1234);
        prepare();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!clr && !en && !act && !wr_en, "R1", "strobes in reset", {clr, en, act, wr_en}, 0);
        chk(!done_o && !restart_o, "R1", "status in reset", {done_o, restart_o}, 0);
        chk(class_o == '0, "R1", "class in reset", class_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!clr && !en && !act && !done_o, "R1", "idle after reset", {clr, en, act, done_o}, 0);
        mon_on = 1;

        fill_random(32'h00c0ffee);
        run(1, 0, "random lat1");

        fill_random(32'h0badf00d);
        run(3, 1, "random lat3 busy start");

        // R9: tie between indices 1 and 3, lowest wins
        fill_random(32'h55);
        for (int n = 0; n < NMAX; n++) for (int k = 0; k < FANMAX; k++) wt[LAYERS-1][n][k] = 0;
        bs[LAYERS-1][0] = 5; bs[LAYERS-1][1] = 9; bs[LAYERS-1][2] = 2; bs[LAYERS-1][3] = 9;
        run(2, 0, "tie");

        // R9: all outputs clamp to zero, index 0 wins; R10 class held from previous run
        fill_random(32'h77);
        for (int n = 0; n < NMAX; n++) begin
            for (int k = 0; k < FANMAX; k++) wt[LAYERS-1][n][k] = 0;
            bs[LAYERS-1][n] = -4;
        end
        run(1, 0, "all zero");

        // R9: maximum at the last index
        fill_random(32'h99);
        for (int n = 0; n < NMAX; n++) for (int k = 0; k < FANMAX; k++) wt[LAYERS-1][n][k] = 0;
        bs[LAYERS-1][0] = 1; bs[LAYERS-1][1] = 2; bs[LAYERS-1][2] = 3; bs[LAYERS-1][3] = 7;
        run(4, 0, "last wins");

        mon_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule